// File: doc/BRIEF.md
# Disk Write Data Separator and Recorder

This block sits on the write side of a disk drive emulator and records what the controller writes into the track RAM. The controller raises a write gate and an erase gate. While both are high, it sends a single pulse line that carries both clock and data. Every bit cell opens with a clock pulse. A second pulse near the middle of the cell means a 1. When no second pulse comes, the bit is 0. The block separates the data pulses from the clock pulses and shifts the recovered bits, most significant bit first, into 16-bit words. It commits each finished word to RAM with a one-cycle write strobe.

The RAM address is built from four parts: the cylinder, the head, the sector, and a word index within the sector. The rotation model outside the block supplies the current sector and the word position under the head. While the block is not writing, it replays the track: each time the word position advances, it issues a one-cycle read strobe for that word. The controller raises the write gate either at the start of a sector, which rewrites the whole sector, or in a gap between records, which keeps the leading records and rewrites only the later ones. In both cases the first word is written at the word position present when writing begins.

If the clock pulses stop for two cell periods, the block flags a framing error and writes nothing more until the gates drop.

Top module: `disk_wr_recorder`

## Requirements
- R1: No RAM write occurs unless `write_gate` and `erase_gate` are both high. With `erase_gate` low, a full pulse stream produces no write.
- R2: Bit cells are timed from the clock pulse that opens each cell, with the cell lasting CELL_CYC clock cycles (75 by default).
  - A pulse arriving at least CELL_CYC/4 cycles and less than 3*CELL_CYC/4 cycles after the cell's clock pulse is a data pulse, and makes the bit 1.
  - A pulse arriving 3*CELL_CYC/4 cycles or later closes the cell and opens the next one.
  - A pulse arriving earlier than CELL_CYC/4 cycles is ignored.
  - A cell that sees no data pulse holds a 0.
- R3: Bits are packed most significant bit first into 16-bit words. Each completed word appears on `ram_wdata` with `ram_we` high for exactly one cycle.
- R4: The write address is {cyl, head, sector, word index}, with cyl in bits [17:10], head in bit [9], sector in bits [8:5] and word index in bits [4:0]. Cylinder, head and sector are latched when writing begins, so later changes to those inputs do not move the address.
- R5: The first word of a write goes to the `word_pos` present in the cycle that writing begins, and each later word goes to the next index. A write that begins at position 0 rewrites all 32 words of the sector. A write that begins at a later position leaves the earlier words untouched.
- R6: Words that arrive after word index 31 has been written are discarded.
- R7: While the block is not writing, each change of `word_pos` produces one `ram_re` pulse whose `ram_addr` is the live {cyl, head, sector, word_pos}. While writing, no read strobe is issued. This includes a position change in the same cycle that writing begins.
- R8: When the gates drop, any partly assembled word is discarded and is never written.
- R9: If no clock pulse arrives within 2*CELL_CYC cycles of the last one, `frame_err` goes high and stays high while the gates stay up, and no further word is written. `frame_err` clears once a gate drops.
- R10: After reset, `ram_we`, `ram_re` and `frame_err` are all low.
- R11: `ram_we` and `ram_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| write_gate | input | 1 | Write gate from the controller |
| erase_gate | input | 1 | Erase gate from the controller |
| wr_pulse | input | 1 | Combined clock-and-data pulse line |
| cyl | input | 8 | Current cylinder |
| head | input | 1 | Current head |
| sector | input | 4 | Current sector from the rotation model |
| word_pos | input | 5 | Word position under the head within the sector |
| ram_addr | output | 18 | RAM address {cyl, head, sector, word} |
| ram_wdata | output | 16 | Word to write |
| ram_we | output | 1 | One-cycle write strobe |
| ram_re | output | 1 | One-cycle read-back strobe |
| frame_err | output | 1 | Missing clock pulse detected |

## Verification
Two events can fall in the same cycle: the read-back strobe triggered by an advance of the word position, and the switch from replay to writing. The bench provokes this by changing `word_pos` on the same edge that raises the write gate. It then judges the result in two ways: no read strobe may appear, and the first written word must land at the new position. A second overlap is a write strobe against a read strobe. This is checked by counting every cycle in which both are high and requiring that count to be zero, including while `word_pos` moves during a write.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic {
    SEP_HUNT = 1'b0,
    SEP_CELL = 1'b1
  } sep_state_e;
endpackage

// File: rtl/wr_pulse_sep.sv
module wr_pulse_sep
  import dwr_pkg::*;
#(
  parameter int CELL_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse,
  output logic bit_vld,
  output logic bit_val,
  output logic ferr
);
  localparam int EARLY = CELL_CYC / 4;
  localparam int LATE  = (3 * CELL_CYC) / 4;
  localparam int LOSS  = 2 * CELL_CYC;
  localparam int CW    = $clog2(LOSS + 1);

  logic        p1_q, p2_q;
  sep_state_e  st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic        seen_q, seen_n;
  logic        bv_q, bv_n;
  logic        b_q, b_n;
  logic        fe_q, fe_n;
  logic        pedge;

  assign pedge = p1_q & ~p2_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    seen_n = seen_q;
    bv_n   = 1'b0;
    b_n    = b_q;
    fe_n   = fe_q;
    if (!en) begin
      st_n   = SEP_HUNT;
      cnt_n  = '0;
      seen_n = 1'b0;
      fe_n   = 1'b0;
    end else begin
      case (st_q)
        SEP_HUNT: begin
          if (pedge && !fe_q) begin
            st_n   = SEP_CELL;
            cnt_n  = '0;
            seen_n = 1'b0;
          end
        end
        default: begin
          if (pedge) begin
            if (cnt_q >= CW'(LATE)) begin
              bv_n   = 1'b1;
              b_n    = seen_q;
              cnt_n  = '0;
              seen_n = 1'b0;
            end else begin
              if (cnt_q >= CW'(EARLY)) begin
                seen_n = 1'b1;
              end
              cnt_n = cnt_q + 1'b1;
            end
          end else if (cnt_q == CW'(LOSS - 1)) begin
            fe_n  = 1'b1;
            st_n  = SEP_HUNT;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q   <= 1'b0;
      p2_q   <= 1'b0;
      st_q   <= SEP_HUNT;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      bv_q   <= 1'b0;
      b_q    <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      p1_q   <= pulse;
      p2_q   <= p1_q;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      bv_q   <= bv_n;
      b_q    <= b_n;
      fe_q   <= fe_n;
    end
  end

  assign bit_vld = bv_q;
  assign bit_val = b_q;
  assign ferr    = fe_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fe_q) && $past(en) && en) |-> fe_q); // R9

  AST_NO_BIT_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q |=> !bv_q); // R9
endmodule

// File: rtl/wr_word_pack.sv
module wr_word_pack #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  output logic                 word_vld,
  output logic [WORD_BITS-1:0] word
);
  localparam int BCW = $clog2(WORD_BITS);

  logic [WORD_BITS-1:0] sh_q, sh_n;
  logic [BCW-1:0]       bc_q, bc_n;
  logic                 wv_q, wv_n;
  logic [WORD_BITS-1:0] w_q, w_n;

  always_comb begin
    sh_n = sh_q;
    bc_n = bc_q;
    wv_n = 1'b0;
    w_n  = w_q;
    if (!en) begin
      bc_n = '0;
      sh_n = '0;
    end else if (bit_vld) begin
      sh_n = {sh_q[WORD_BITS-2:0], bit_val};
      if (bc_q == BCW'(WORD_BITS - 1)) begin
        wv_n = 1'b1;
        w_n  = {sh_q[WORD_BITS-2:0], bit_val};
        bc_n = '0;
      end else begin
        bc_n = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= '0;
      wv_q <= 1'b0;
      w_q  <= '0;
    end else begin
      sh_q <= sh_n;
      bc_q <= bc_n;
      wv_q <= wv_n;
      w_q  <= w_n;
    end
  end

  assign word_vld = wv_q;
  assign word     = w_q;

  AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |=> !wv_q); // R3

  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bc_q == '0)); // R8
endmodule

// File: rtl/wr_addr_ctl.sv
module wr_addr_ctl #(
  parameter int CYL_W     = 8,
  parameter int HEAD_W    = 1,
  parameter int SEC_W     = 4,
  parameter int SEC_WORDS = 32,
  parameter int WORD_BITS = 16,
  localparam int WORD_W   = $clog2(SEC_WORDS),
  localparam int BASE_W   = CYL_W + HEAD_W + SEC_W,
  localparam int AW       = BASE_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_on,
  input  logic                 word_vld,
  input  logic [WORD_BITS-1:0] word,
  input  logic [CYL_W-1:0]     cyl,
  input  logic [HEAD_W-1:0]    head,
  input  logic [SEC_W-1:0]     sector,
  input  logic [WORD_W-1:0]    word_pos,
  output logic [AW-1:0]        ram_addr,
  output logic [WORD_BITS-1:0] ram_wdata,
  output logic                 ram_we,
  output logic                 ram_re
);
  logic                 on_q;
  logic [WORD_W-1:0]    pos_q;
  logic [BASE_W-1:0]    base_q, base_n;
  logic [WORD_W-1:0]    idx_q, idx_n;
  logic                 full_q, full_n;
  logic [AW-1:0]        addr_q, addr_n;
  logic [WORD_BITS-1:0] data_q, data_n;
  logic                 we_q, we_n;
  logic                 re_q, re_n;
  logic                 rise;

  assign rise = wr_on & ~on_q;

  always_comb begin
    base_n = base_q;
    idx_n  = idx_q;
    full_n = full_q;
    addr_n = addr_q;
    data_n = data_q;
    we_n   = 1'b0;
    re_n   = 1'b0;
    if (rise) begin
      base_n = {cyl, head, sector};
      idx_n  = word_pos;
      full_n = 1'b0;
    end else if (wr_on && word_vld && !full_q) begin
      we_n   = 1'b1;
      addr_n = {base_q, idx_q};
      data_n = word;
      if (idx_q == WORD_W'(SEC_WORDS - 1)) begin
        full_n = 1'b1;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
    if (!wr_on && (word_pos != pos_q)) begin
      re_n   = 1'b1;
      addr_n = {cyl, head, sector, word_pos};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      pos_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      on_q   <= wr_on;
      pos_q  <= word_pos;
      base_q <= base_n;
      idx_q  <= idx_n;
      full_q <= full_n;
      addr_q <= addr_n;
      data_q <= data_n;
      we_q   <= we_n;
      re_q   <= re_n;
    end
  end

  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;
  assign ram_we    = we_q;
  assign ram_re    = re_q;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && re_q)); // R11

  AST_RE_ONLY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    re_q |-> !$past(wr_on)); // R7

  AST_NO_WRITE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && on_q |=> !we_q); // R6
endmodule

// File: rtl/disk_wr_recorder.sv
module disk_wr_recorder #(
  parameter int CLK_NS    = 8,
  parameter int CELL_NS   = 600,
  parameter int CYL_W     = 8,
  parameter int HEAD_W    = 1,
  parameter int SEC_W     = 4,
  parameter int SEC_WORDS = 32,
  parameter int WORD_BITS = 16,
  localparam int CELL_CYC = CELL_NS / CLK_NS,
  localparam int WORD_W   = $clog2(SEC_WORDS),
  localparam int AW       = CYL_W + HEAD_W + SEC_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 write_gate,
  input  logic                 erase_gate,
  input  logic                 wr_pulse,
  input  logic [CYL_W-1:0]     cyl,
  input  logic [HEAD_W-1:0]    head,
  input  logic [SEC_W-1:0]     sector,
  input  logic [WORD_W-1:0]    word_pos,
  output logic [AW-1:0]        ram_addr,
  output logic [WORD_BITS-1:0] ram_wdata,
  output logic                 ram_we,
  output logic                 ram_re,
  output logic                 frame_err
);
  logic rs1_q, rs2_q;
  logic gates_on, wr_on;
  logic bit_vld, bit_val, ferr;
  logic word_vld;
  logic [WORD_BITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign gates_on = write_gate & erase_gate;
  assign wr_on    = gates_on & ~ferr;

  wr_pulse_sep #(.CELL_CYC(CELL_CYC)) u_sep (
    .clk     (clk),
    .rst_n   (rs2_q),
    .en      (gates_on),
    .pulse   (wr_pulse),
    .bit_vld (bit_vld),
    .bit_val (bit_val),
    .ferr    (ferr)
  );

  wr_word_pack #(.WORD_BITS(WORD_BITS)) u_pack (
    .clk      (clk),
    .rst_n    (rs2_q),
    .en       (wr_on),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .word_vld (word_vld),
    .word     (word)
  );

  wr_addr_ctl #(
    .CYL_W     (CYL_W),
    .HEAD_W    (HEAD_W),
    .SEC_W     (SEC_W),
    .SEC_WORDS (SEC_WORDS),
    .WORD_BITS (WORD_BITS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rs2_q),
    .wr_on     (wr_on),
    .word_vld  (word_vld),
    .word      (word),
    .cyl       (cyl),
    .head      (head),
    .sector    (sector),
    .word_pos  (word_pos),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re)
  );

  assign frame_err = ferr;

  AST_WE_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rs2_q)
    ram_we |-> $past(write_gate && erase_gate)); // R1

  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rs2_q)
    frame_err |=> !ram_we); // R9
endmodule

// File: tb/tb_disk_wr_recorder.sv
module tb_disk_wr_recorder;
  localparam int CELL = 75;
  localparam int SECW = 32;

  logic        clk, rst_n;
  logic        write_gate, erase_gate, wr_pulse;
  logic [7:0]  cyl;
  logic [0:0]  head;
  logic [3:0]  sector;
  logic [4:0]  word_pos;
  logic [17:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        ram_we, ram_re, frame_err;

  disk_wr_recorder dut (
    .clk(clk), .rst_n(rst_n), .write_gate(write_gate), .erase_gate(erase_gate),
    .wr_pulse(wr_pulse), .cyl(cyl), .head(head), .sector(sector), .word_pos(word_pos),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  logic [17:0] wlog_a [0:63];
  logic [15:0] wlog_d [0:63];
  int          wn = 0;
  int          ren = 0;
  logic [17:0] re_last;
  int          both_cnt = 0;
  logic [15:0] tx [0:39];

  always @(negedge clk) begin
    if (ram_we && wn < 64) begin
      wlog_a[wn] = ram_addr;
      wlog_d[wn] = ram_wdata;
      wn = wn + 1;
    end
    if (ram_re) begin
      ren = ren + 1;
      re_last = ram_addr;
    end
    if (ram_we && ram_re) both_cnt = both_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 195000 && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [17:0] exp_addr(input logic [7:0] c, input logic h,
                                           input logic [3:0] s, input int w);
    return {c, h, s, 5'(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cell(input bit b, input bit glitch);
    for (int c = 0; c < CELL; c++) begin
      wr_pulse = (c == 0) || (b && c == 37) || (glitch && c == 5);
      @(negedge clk);
    end
    wr_pulse = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input bit glitch);
    for (int i = 15; i >= 0; i--) send_cell(w[i], glitch);
  endtask

  task automatic close_and_drop();
    wr_pulse = 1'b1;
    @(negedge clk);
    wr_pulse = 1'b0;
    tick(12);
    write_gate = 1'b0;
    erase_gate = 1'b0;
    tick(4);
  endtask

  task automatic check_writes(input int base_n, input int nexp, input int start,
                              input logic [7:0] c, input logic h, input logic [3:0] s,
                              input string req);
    chk(wn - base_n == nexp, req, wn - base_n, nexp);
    for (int i = 0; i < nexp; i++) begin
      if (base_n + i < wn) begin
        chk(wlog_a[base_n + i] == exp_addr(c, h, s, start + i), req,
            wlog_a[base_n + i], exp_addr(c, h, s, start + i));
        chk(wlog_d[base_n + i] == tx[i], req, wlog_d[base_n + i], tx[i]);
      end
    end
  endtask

  initial begin
    logic [7:0] c0;
    logic       h0;
    logic [3:0] s0;
    int b0, r0;
    void'($urandom(32'd777));
    rst_n = 1'b0;
    write_gate = 1'b0; erase_gate = 1'b0; wr_pulse = 1'b0;
    cyl = 8'd0; head = 1'b0; sector = 4'd0; word_pos = 5'd0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10 reset state
    chk(ram_we == 1'b0, "R10", ram_we, 0);
    chk(ram_re == 1'b0, "R10", ram_re, 0);
    chk(frame_err == 1'b0, "R10", frame_err, 0);

    // R7 replay read strobe on position change
    c0 = 8'($urandom); h0 = 1'($urandom); s0 = 4'($urandom);
    cyl = c0; head = h0; sector = s0;
    r0 = ren;
    word_pos = 5'd7;
    tick(3);
    chk(ren - r0 == 1, "R7", ren - r0, 1);
    chk(re_last == exp_addr(c0, h0, s0, 7), "R7", re_last, exp_addr(c0, h0, s0, 7));
    r0 = ren;
    tick(6);
    chk(ren == r0, "R7", ren - r0, 0);

    // R1 erase gate low: no write
    b0 = wn;
    write_gate = 1'b1;
    tx[0] = 16'hA5A5; tx[1] = 16'h1234;
    send_word(tx[0], 1'b0); send_word(tx[1], 1'b0);
    close_and_drop();
    chk(wn == b0, "R1", wn - b0, 0);

    // R3 R4 R5 full sector write from position 0
    word_pos = 5'd0;
    tick(4);
    tx[0] = 16'h0000; tx[1] = 16'hFFFF; tx[2] = 16'h8001;
    for (int i = 3; i < SECW; i++) tx[i] = 16'($urandom);
    b0 = wn;
    write_gate = 1'b1; erase_gate = 1'b1;
    r0 = ren;
    for (int i = 0; i < SECW; i++) begin
      if (i == 10) begin
        word_pos = 5'd3;
        sector = s0 + 4'd1;
        cyl = c0 + 8'd1;
      end
      send_word(tx[i], 1'b0);
    end
    close_and_drop();
    check_writes(b0, SECW, 0, c0, h0, s0, "R5");
    chk(ren == r0, "R7", ren - r0, 0);
    sector = s0; cyl = c0;

    // R6 overflow past last word
    word_pos = 5'd30;
    tick(4);
    for (int i = 0; i < 3; i++) tx[i] = 16'($urandom);
    b0 = wn;
    write_gate = 1'b1; erase_gate = 1'b1;
    for (int i = 0; i < 3; i++) send_word(tx[i], 1'b0);
    close_and_drop();
    check_writes(b0, 2, 30, c0, h0, s0, "R6");

    // R5 R7 update write: position change in the same cycle as gate rise
    erase_gate = 1'b1;
    tick(4);
    r0 = ren;
    for (int i = 0; i < 4; i++) tx[i] = 16'($urandom);
    b0 = wn;
    word_pos = 5'd12;
    write_gate = 1'b1;
    tick(2);
    chk(ren == r0, "R7", ren - r0, 0);
    for (int i = 0; i < 4; i++) send_word(tx[i], 1'b0);
    close_and_drop();
    check_writes(b0, 4, 12, c0, h0, s0, "R5");

    // R8 partial word discarded on gate drop
    word_pos = 5'd2;
    tick(4);
    tx[0] = 16'($urandom);
    b0 = wn;
    write_gate = 1'b1; erase_gate = 1'b1;
    send_word(tx[0], 1'b0);
    for (int i = 0; i < 7; i++) send_cell(1'b1, 1'b0);
    close_and_drop();
    check_writes(b0, 1, 2, c0, h0, s0, "R8");

    // R2 early pulses ignored, data pulses decoded
    word_pos = 5'd20;
    tick(4);
    tx[0] = 16'h5A0F; tx[1] = 16'($urandom);
    b0 = wn;
    write_gate = 1'b1; erase_gate = 1'b1;
    send_word(tx[0], 1'b1);
    send_word(tx[1], 1'b1);
    close_and_drop();
    check_writes(b0, 2, 20, c0, h0, s0, "R2");

    // R9 framing error on lost clock
    word_pos = 5'd5;
    tick(4);
    b0 = wn;
    write_gate = 1'b1; erase_gate = 1'b1;
    for (int i = 0; i < 5; i++) send_cell(1'b1, 1'b0);
    tick(2 * CELL + 50);
    chk(frame_err == 1'b1, "R9", frame_err, 1);
    send_word(16'hC3C3, 1'b0);
    send_word(16'h3C3C, 1'b0);
    wr_pulse = 1'b1; @(negedge clk); wr_pulse = 1'b0;
    tick(12);
    chk(frame_err == 1'b1, "R9", frame_err, 1);
    chk(wn == b0, "R9", wn - b0, 0);
    write_gate = 1'b0; erase_gate = 1'b0;
    tick(4);
    chk(frame_err == 1'b0, "R9", frame_err, 0);

    // R11 ports never both active
    chk(both_cnt == 0, "R11", both_cnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule